// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Level Flags

This block is a first-in first-out buffer whose write and read ports run on clocks that have no fixed relation to each other. Words enter on the write clock when the active-low write enable is sampled low, and leave on the read clock. While master reset is held low, the block samples a timing-mode input. That mode then holds until the next master reset. In the standard mode a read request moves the oldest word onto the output. In the fall-through mode the oldest word lands in a one-word output stage by itself, and a read request only discards the presented word and fetches the next one.

Two shared flag outputs change meaning with the mode. In standard mode they report "no words" and "no room". In fall-through mode they report "output valid" and "room available". A half-full flag and two active-low threshold flags are present in both modes. The two threshold flags are almost-empty and almost-full, and each compares the fill level with its own offset. The offsets are sampled with the mode during master reset. A partial reset clears only the pointers, and every flag is then recomputed using the mode and offsets already in force.

The fall-through output stage is a two-state machine. OS_EMPTY means no word is presented and OS_HOLD means a word is presented. The transition *load* (OS_EMPTY to OS_HOLD) fires when the memory holds a word. The transition *refill* (OS_HOLD to OS_HOLD) fires when a read takes the word and the memory can supply another. The transition *drain* (OS_HOLD to OS_EMPTY) fires when a read takes the word and the memory is empty. In standard mode the machine stays in OS_EMPTY.

Top module: `dualmode_fifo`

## Requirements
- R1: `fwft_sel` is sampled on every clock edge while `mrs_n` is low, with 1 selecting fall-through mode and 0 selecting standard mode. The mode does not change while `mrs_n` stays high.
- R2: In standard mode, `empty_or` is 1 exactly when the read side sees no stored words. `full_ir` is 1 exactly when the write side counts DEPTH stored words.
- R3: In standard mode, each read-clock edge with `ren_n` low and at least one stored word places the oldest word on `dout`. Words come out in the order they were written.
- R4: In fall-through mode, the first word written into an empty FIFO appears on `dout` and sets `empty_or` to 1 without any read request. While `ren_n` stays high, `dout` holds that word, and each edge with `ren_n` low advances to the next word.
- R5: In fall-through mode, `full_ir` is 1 while the memory holds fewer than DEPTH words. Including the output stage, the FIFO therefore accepts DEPTH+1 words before `full_ir` drops to 0.
- R6: A write while full, a standard-mode read while empty and a fall-through read while no word is presented are all ignored. No pointer moves, `dout` is unchanged, and no rejected word ever appears on the output.
- R7: `half_full` is 1 when the write-side level is greater than DEPTH/2.
- R8: `almost_empty_n` is 0 when the read-side level is less than or equal to the latched almost-empty offset. In fall-through mode the read-side level includes the presented word.
- R9: `almost_full_n` is 0 when the write-side level is greater than or equal to DEPTH minus the latched almost-full offset.
- R10: `ae_ofs` and `af_ofs` are sampled only while `mrs_n` is low. A partial reset (`prs_n` low) empties the FIFO and leaves the mode and both offsets unchanged.
- R11: After either reset, the flags reflect an empty FIFO under the mode in force. In standard mode that is `empty_or`=1 and `full_ir`=0; in fall-through mode it is `empty_or`=0 and `full_ir`=1. In both modes `half_full`=0, `almost_empty_n`=0, `almost_full_n`=1 (for an almost-full offset below DEPTH) and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low; clears pointers and samples mode and offsets |
| prs_n | input | 1 | Partial reset, active low; clears pointers only |
| fwft_sel | input | 1 | Timing mode sampled during master reset (1 = fall-through) |
| ae_ofs | input | AW | Almost-empty offset sampled during master reset |
| af_ofs | input | AW | Almost-full offset sampled during master reset |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| ren_n | input | 1 | Read enable, active low |
| dout | output | DW | Read data |
| empty_or | output | 1 | Empty (standard) or output valid (fall-through) |
| full_ir | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Level above DEPTH/2 |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a 4-bit address, so DEPTH is 16. With only sixteen locations, every fill threshold can be reached with a handful of writes. This covers the half-full edge between 8 and 9 words, the almost-full edge at 14 words for an offset of 2, and the true full point in both modes, including the seventeenth word that fall-through mode holds in its output stage. The read clock runs at a period unrelated to the write clock, so each flag is checked after the pointer synchronizers have settled.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    // Fall-through output stage: no word presented / word presented
    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_HOLD  = 1'b1
    } ostage_t;

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side #(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          mrs_n,
    input  logic          fwft_sel,
    input  logic [AW-1:0] af_ofs,
    input  logic          wen_n,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_ir,
    output logic          half_full,
    output logic          almost_full_n
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic          fwft_q;
    logic [AW-1:0] af_ofs_q;
    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wgray_q;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] level;
    logic [PW-1:0] af_thr;
    logic          full;

    // configuration captured only while master reset is held
    always_ff @(posedge wclk) begin
        if (!mrs_n) begin
            fwft_q   <= fwft_sel;
            af_ofs_q <= af_ofs;
        end
    end

    assign rbin_s  = g2b(rgray_s);
    assign level   = wbin_q - rbin_s;
    assign full    = (level == PW'(DEPTH));
    assign we      = !wen_n && !full;
    assign wbin_nx = wbin_q + 1'b1;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (we) begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign waddr         = wbin_q[AW-1:0];
    assign wgray         = wgray_q;
    assign af_thr        = PW'(DEPTH) - {1'b0, af_ofs_q};
    assign full_ir       = fwft_q ? !full : full;
    assign half_full     = (level > PW'(DEPTH / 2));
    assign almost_full_n = !(level >= af_thr);

    // R6
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && !wen_n) |=> (wbin_q == $past(wbin_q)));

    // R6
    level_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        level <= PW'(DEPTH));

    // R1
    mode_hold_w_chk: assert property (@(posedge wclk) disable iff (!mrs_n)
        $past(mrs_n) |-> $stable(fwft_q));

endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side
    import dmf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          mrs_n,
    input  logic          fwft_sel,
    input  logic [AW-1:0] ae_ofs,
    input  logic          ren_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] ram_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          empty_or,
    output logic          almost_empty_n
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    ostage_t       state_q;
    ostage_t       state_nx;
    logic          fwft_q;
    logic [AW-1:0] ae_ofs_q;
    logic [PW-1:0] rbin_q;
    logic [PW-1:0] rgray_q;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_s;
    logic [PW:0]   rlevel;
    logic [DW-1:0] dout_q;
    logic          core_empty;
    logic          pop;
    logic          held;

    always_ff @(posedge rclk) begin
        if (!mrs_n) begin
            fwft_q   <= fwft_sel;
            ae_ofs_q <= ae_ofs;
        end
    end

    assign wbin_s     = g2b(wgray_s);
    assign core_empty = (rgray_q == wgray_s);

    // next state and memory pop decision
    always_comb begin
        state_nx = state_q;
        pop      = 1'b0;
        if (!fwft_q) begin
            pop = !ren_n && !core_empty;
        end else begin
            unique case (state_q)
                OS_EMPTY: begin
                    if (!core_empty) begin
                        pop      = 1'b1;
                        state_nx = OS_HOLD;
                    end
                end
                OS_HOLD: begin
                    if (!ren_n) begin
                        if (!core_empty) begin
                            pop = 1'b1;
                        end else begin
                            state_nx = OS_EMPTY;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_EMPTY;
        end else begin
            state_q <= state_nx;
        end
    end

    // output data and read pointer
    assign rbin_nx = rbin_q + 1'b1;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (pop) begin
            dout_q  <= ram_q;
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    assign held           = fwft_q && (state_q == OS_HOLD);
    assign rlevel         = {1'b0, wbin_s - rbin_q} + {{PW{1'b0}}, held};
    assign almost_empty_n = !(rlevel <= {{(PW + 1 - AW){1'b0}}, ae_ofs_q});
    assign empty_or       = fwft_q ? held : core_empty;
    assign raddr          = rbin_q[AW-1:0];
    assign rgray          = rgray_q;
    assign dout           = dout_q;

    // R6
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft_q && core_empty && !ren_n) |=> $stable(dout_q));

    // R4
    fall_through_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (fwft_q && state_q == OS_EMPTY && !core_empty) |=> (state_q == OS_HOLD));

    // R4
    hold_stable_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (fwft_q && state_q == OS_HOLD && ren_n) |=> $stable(dout_q));

    // R8
    rlevel_bound_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        rlevel <= (PW + 1)'(DEPTH + 1));

    // R1
    mode_hold_r_chk: assert property (@(posedge rclk) disable iff (!mrs_n)
        $past(mrs_n) |-> $stable(fwft_q));

endmodule

// File: rtl/dualmode_fifo.sv
module dualmode_fifo #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrs_n,
    input  logic          prs_n,
    input  logic          fwft_sel,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    input  logic          wen_n,
    input  logic [DW-1:0] din,
    input  logic          ren_n,
    output logic [DW-1:0] dout,
    output logic          empty_or,
    output logic          full_ir,
    output logic          half_full,
    output logic          almost_empty_n,
    output logic          almost_full_n
);

    localparam int PW = AW + 1;

    logic          ptr_rst_n;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray_s;
    logic [DW-1:0] ram_q;

    assign ptr_rst_n = mrs_n & prs_n;

    dmf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (ram_q)
    );

    dmf_sync #(.W(PW)) u_w2r (
        .clk   (rclk),
        .rst_n (ptr_rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dmf_sync #(.W(PW)) u_r2w (
        .clk   (wclk),
        .rst_n (ptr_rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    dmf_wr_side #(.AW(AW)) u_wr (
        .wclk          (wclk),
        .rst_n         (ptr_rst_n),
        .mrs_n         (mrs_n),
        .fwft_sel      (fwft_sel),
        .af_ofs        (af_ofs),
        .wen_n         (wen_n),
        .rgray_s       (rgray_s),
        .we            (we),
        .waddr         (waddr),
        .wgray         (wgray),
        .full_ir       (full_ir),
        .half_full     (half_full),
        .almost_full_n (almost_full_n)
    );

    dmf_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .rclk           (rclk),
        .rst_n          (ptr_rst_n),
        .mrs_n          (mrs_n),
        .fwft_sel       (fwft_sel),
        .ae_ofs         (ae_ofs),
        .ren_n          (ren_n),
        .wgray_s        (wgray_s),
        .ram_q          (ram_q),
        .raddr          (raddr),
        .rgray          (rgray),
        .dout           (dout),
        .empty_or       (empty_or),
        .almost_empty_n (almost_empty_n)
    );

endmodule

// File: tb/test_dualmode_fifo.sv
module test_dualmode_fifo;

    localparam int DW = 8;
    localparam int AW = 4;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrs_n = 1'b0;
    logic          prs_n = 1'b1;
    logic          fwft_sel = 1'b0;
    logic [AW-1:0] ae_ofs = 4'd3;
    logic [AW-1:0] af_ofs = 4'd2;
    logic          wen_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic          ren_n = 1'b1;
    logic [DW-1:0] dout;
    logic          empty_or;
    logic          full_ir;
    logic          half_full;
    logic          almost_empty_n;
    logic          almost_full_n;

    int checks = 0;
    int fails  = 0;

    always #10 wclk = ~wclk;   // 50 MHz write clock
    always #15 rclk = ~rclk;   // unrelated read clock

    dualmode_fifo #(.DW(DW), .AW(AW)) i_dualmode_fifo (
        .wclk           (wclk),
        .rclk           (rclk),
        .mrs_n          (mrs_n),
        .prs_n          (prs_n),
        .fwft_sel       (fwft_sel),
        .ae_ofs         (ae_ofs),
        .af_ofs         (af_ofs),
        .wen_n          (wen_n),
        .din            (din),
        .ren_n          (ren_n),
        .dout           (dout),
        .empty_or       (empty_or),
        .full_ir        (full_ir),
        .half_full      (half_full),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // let both pointer synchronizers settle; ends on a write-clock falling edge
    task automatic settle();
        repeat (8) @(posedge rclk);
        repeat (3) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic wr(input logic [DW-1:0] v);
        @(negedge wclk);
        wen_n = 1'b0;
        din   = v;
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic rd();
        @(negedge rclk);
        ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1;
        settle();
    endtask

    task automatic master_reset(input logic m, input logic [AW-1:0] ae, input logic [AW-1:0] af);
        @(negedge wclk);
        mrs_n    = 1'b0;
        fwft_sel = m;
        ae_ofs   = ae;
        af_ofs   = af;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        mrs_n = 1'b1;
        settle();
    endtask

    task automatic t_reset_std();
        master_reset(1'b0, 4'd3, 4'd2);
        chk("R11 std empty after reset", empty_or, 1);
        chk("R2 std full after reset", full_ir, 0);
        chk("R11 half_full after reset", half_full, 0);
        chk("R11 almost_empty_n after reset", almost_empty_n, 0);
        chk("R11 almost_full_n after reset", almost_full_n, 1);
        chk("R11 dout after reset", dout, 0);
    endtask

    task automatic t_std_order();
        for (int i = 0; i < 5; i++) wr(8'hA0 + 8'(i));
        settle();
        chk("R2 std not empty", empty_or, 0);
        chk("R3 std no read yet, dout 0", dout, 0);
        chk("R8 level 5 above offset 3", almost_empty_n, 1);
        for (int i = 0; i < 5; i++) begin
            rd();
            chk("R3 std read order", dout, 8'hA0 + 8'(i));
        end
        chk("R2 std empty after drain", empty_or, 1);
        rd();
        chk("R6 read while empty ignored", dout, 8'hA4);
    endtask

    task automatic t_std_levels();
        for (int i = 0; i < 3; i++) wr(8'h30 + 8'(i));
        settle();
        chk("R8 level 3 equals offset", almost_empty_n, 0);
        wr(8'h33);
        settle();
        chk("R8 level 4 above offset", almost_empty_n, 1);
        for (int i = 4; i < 8; i++) wr(8'h30 + 8'(i));
        settle();
        chk("R7 level 8 not above half", half_full, 0);
        wr(8'h38);
        settle();
        chk("R7 level 9 above half", half_full, 1);
        for (int i = 9; i < 13; i++) wr(8'h30 + 8'(i));
        settle();
        chk("R9 level 13 below threshold", almost_full_n, 1);
        wr(8'h3D);
        settle();
        chk("R9 level 14 at threshold", almost_full_n, 0);
        chk("R2 level 14 not full", full_ir, 0);
        wr(8'h3E);
        wr(8'h3F);
        settle();
        chk("R2 std full at DEPTH", full_ir, 1);
        wr(8'hEE);
        settle();
        chk("R6 still full after rejected write", full_ir, 1);
        for (int i = 0; i < 16; i++) begin
            rd();
            chk("R6 full drain order, rejected word absent", dout, 8'h30 + 8'(i));
        end
        chk("R6 empty after draining 16", empty_or, 1);
        rd();
        chk("R6 extra read ignored", dout, 8'h3F);
    endtask

    task automatic t_partial();
        for (int i = 0; i < 3; i++) wr(8'h50 + 8'(i));
        settle();
        @(negedge wclk);
        prs_n    = 1'b0;
        fwft_sel = 1'b1;
        ae_ofs   = 4'd0;
        af_ofs   = 4'd0;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        prs_n = 1'b1;
        settle();
        chk("R10 partial reset empties", empty_or, 1);
        chk("R11 dout cleared by partial reset", dout, 0);
        chk("R11 half_full after partial reset", half_full, 0);
        wr(8'h61);
        settle();
        chk("R10 standard mode kept", empty_or, 0);
        chk("R10 no fall-through in kept mode", dout, 0);
        chk("R10 almost-empty offset kept", almost_empty_n, 0);
        rd();
        chk("R3 read after partial reset", dout, 8'h61);
    endtask

    task automatic t_reset_fwft();
        master_reset(1'b1, 4'd2, 4'd3);
        chk("R1 fall-through not ready after reset", empty_or, 0);
        chk("R11 input ready after reset", full_ir, 1);
        chk("R11 half_full after reset", half_full, 0);
        chk("R11 almost_empty_n after reset", almost_empty_n, 0);
        chk("R11 almost_full_n after reset", almost_full_n, 1);
    endtask

    task automatic t_fwft_basic();
        wr(8'h70);
        settle();
        chk("R4 first word ready", empty_or, 1);
        chk("R4 first word falls through", dout, 8'h70);
        wr(8'h71);
        wr(8'h72);
        settle();
        chk("R4 no advance without read", dout, 8'h70);
        rd();
        chk("R4 read advances", dout, 8'h71);
        rd();
        chk("R4 read advances again", dout, 8'h72);
        chk("R4 still ready", empty_or, 1);
        rd();
        chk("R4 ready drops after last", empty_or, 0);
        chk("R6 dout kept after last read", dout, 8'h72);
        rd();
        chk("R6 read while not ready ignored", dout, 8'h72);
    endtask

    task automatic t_fwft_levels();
        wr(8'h80);
        wr(8'h81);
        settle();
        chk("R8 fall-through level 2 at offset", almost_empty_n, 0);
        wr(8'h82);
        settle();
        chk("R8 fall-through level 3 above offset", almost_empty_n, 1);
        chk("R4 head word", dout, 8'h80);
        rd();
        chk("R4 second word", dout, 8'h81);
        rd();
        chk("R4 third word", dout, 8'h82);
        rd();
        chk("R4 drained", empty_or, 0);
    endtask

    task automatic t_fwft_full();
        for (int i = 0; i < 16; i++) wr(8'h90 + 8'(i));
        settle();
        chk("R5 room left with 16 words", full_ir, 1);
        chk("R9 almost full in fall-through", almost_full_n, 0);
        wr(8'hA0);
        settle();
        chk("R5 not ready at DEPTH+1", full_ir, 0);
        wr(8'hEE);
        settle();
        chk("R6 head unchanged by rejected write", dout, 8'h90);
        for (int i = 1; i < 17; i++) begin
            rd();
            chk("R5 fall-through drain order", dout, 8'h90 + 8'(i));
        end
        rd();
        chk("R6 rejected word never presented", empty_or, 0);
        chk("R6 last word kept", dout, 8'hA0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        t_reset_std();
        t_std_order();
        t_std_levels();
        t_partial();
        t_reset_fwft();
        t_fwft_basic();
        t_fwft_levels();
        t_fwft_full();
        finish_run();
    end

endmodule